// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address for a simple in-order core whose branches have one architectural delay slot. In every cycle the decode stage reports whether the instruction at the presented fetch address is a branch. It also reports whether that branch is taken, where it goes, and whether its delay slot should be annulled. The sequencer answers with the next fetch address and a valid bit. A taken branch does not redirect fetch at once. The instruction after it runs first, and fetch then moves to the target.

Internally the sequencer keeps the current fetch address, the following address, and one held target. A taken branch that sits in the delay slot of another taken branch therefore gives a fixed, interleaved order:

1. the first branch;
2. the second branch;
3. the second branch's own sequential slot;
4. a single instruction at the first target;
5. execution resumes at the second target.

An annulled slot is still fetched, but it is presented with its valid bit low, so it has no architectural effect. A stall freezes everything.

The decode inputs always describe the instruction at `fetch_addr_o` in the same cycle. They are consumed only in a cycle where `stall_i` is low, which is called an accepted cycle below.

Top module: `brslot_pc_seq`

## Requirements
- R1: A synchronous reset, with `rst_n` low at a rising edge, presents `RESET_VEC` with its two low bits cleared. The valid bit is 1, and the sequence then continues at that address plus 4.
- R2: An accepted instruction that is not a branch is followed by the instruction at its address plus 4, unless a redirect is pending.
- R3: When a taken branch is accepted with no redirect pending, the next fetch is the branch address plus 4 (its delay slot). The fetch after that is the target.
- R4: A taken branch accepted in the delay slot of an earlier taken branch gives this fetch order: its own address plus 4, then exactly one instruction at the earlier target, then the later target.
- R5: While a later target is held (the cycle after the R4 case), a branch indication is ignored entirely, including its annul flag. The sequence proceeds to the earlier target and then to the held one.
- R6: An accepted branch with the annul flag set, taken or not, makes the next fetch appear with `fetch_valid_o` = 0. The fetch after that is valid and follows the normal sequence.
- R7: Branch inputs presented while `fetch_valid_o` is 0 are ignored.
- R8: A branch that is not taken leaves the address sequence unchanged, and its delay slot is valid unless annulled.
- R9: While `stall_i` is 1, the fetch address and the valid bit hold, and decode inputs are ignored.
- R10: Every fetch address has its two low bits at zero. A target's two low bits are cleared before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Holds the sequencer when 1 |
| br_valid_i | input | 1 | The instruction at `fetch_addr_o` is a branch |
| br_taken_i | input | 1 | That branch is taken |
| br_annul_i | input | 1 | That branch annuls its delay slot |
| br_target_i | input | 32 | Branch target byte address |
| fetch_addr_o | output | 32 | Address of the instruction presented now |
| fetch_valid_o | output | 1 | 0 when the presented instruction is an annulled slot |

## Verification
The bench first targets the nested case, where a taken branch sits in a taken branch's slot. A design that redirected straight to the later target would skip the single instruction at the earlier target, and a plain two-register design would drop the sequential slot. It then pushes a third taken branch into that chain, stalls on a taken branch and on an annulled slot, and presents a taken branch inside an annulled slot. A design that consumed decode inputs under stall would redirect twice, and one that honoured branches in dead slots would jump to a bogus target. Unaligned reset vectors and targets are applied to show whether the low bits leak, and long pseudo-random programs with random stalls are compared against an address-pair model.

// File: rtl/brslot_pkg.sv
// Shared types for the delayed-branch fetch sequencer.
// Assumes a fixed 32-bit byte address space.
package brslot_pkg;
    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // Decode-stage report about the instruction at the current fetch address.
    typedef struct packed {
        logic  br;
        logic  taken;
        logic  annul;
        addr_t target;
    } dec_t;

    // Sequencer state: current/next address, one held target and flags.
    typedef struct packed {
        addr_t pc;
        addr_t npc;
        addr_t pend;
        logic  redir;     // npc holds a branch target, not a sequential address
        logic  pend_vld;  // pend holds a later target waiting behind npc
        logic  slot_kill; // instruction at pc is an annulled slot
    } seq_t;
endpackage

// File: rtl/brslot_align.sv
// Clears the low address bits below the instruction size.
// Assumes ALIGN_BITS is smaller than the address width.
module brslot_align
    import brslot_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 2
) (
    input  addr_t a_i,
    output addr_t a_o
);
    // Per bit: force to zero below the alignment, pass through above it.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b < ALIGN_BITS) begin : g_zero
            assign a_o[b] = 1'b0;
        end else begin : g_pass
            assign a_o[b] = a_i[b];
        end
    end
endmodule

// File: rtl/brslot_next.sv
// Computes the sequencer state that follows an accepted cycle.
// Assumes the decode report describes the instruction at cur_i.pc.
// Purely combinational; the state register decides whether to load it.
module brslot_next
    import brslot_pkg::*;
#(
    parameter int unsigned INSTR_BYTES = 4
) (
    input  seq_t cur_i,
    input  dec_t dec_i,
    output seq_t nxt_o
);
    localparam int unsigned ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam addr_t       STEP       = addr_t'(INSTR_BYTES);

    addr_t tgt_al;
    logic  eff_br;
    logic  eff_tk;

    brslot_align #(.ALIGN_BITS(ALIGN_BITS)) u_tgt_align (
        .a_i (dec_i.target),
        .a_o (tgt_al)
    );

    // A branch counts only in a live slot and when no later target is held.
    always_comb begin
        eff_br = dec_i.br && !cur_i.slot_kill && !cur_i.pend_vld;
        eff_tk = eff_br && dec_i.taken;
    end

    // Next-state selection for the address pair and the held target.
    always_comb begin
        nxt_o           = cur_i;
        nxt_o.slot_kill = eff_br && dec_i.annul;
        if (eff_tk && cur_i.redir) begin
            // Branch in a taken branch's slot: own slot first, keep older target.
            nxt_o.pc       = cur_i.pc + STEP;
            nxt_o.pend     = tgt_al;
            nxt_o.pend_vld = 1'b1;
        end else begin
            nxt_o.pc = cur_i.npc;
            if (eff_tk) begin
                nxt_o.npc   = tgt_al;
                nxt_o.redir = 1'b1;
            end else if (cur_i.pend_vld) begin
                nxt_o.npc      = cur_i.pend;
                nxt_o.redir    = 1'b1;
                nxt_o.pend_vld = 1'b0;
            end else begin
                nxt_o.npc   = cur_i.npc + STEP;
                nxt_o.redir = 1'b0;
            end
        end
    end
endmodule

// File: rtl/brslot_state.sv
// Holds the sequencer state; loads the next state on accepted cycles.
// Assumes a synchronous active-low reset and a power-of-two instruction size.
module brslot_state
    import brslot_pkg::*;
#(
    parameter addr_t       RESET_VEC   = 32'h0000_0100,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  seq_t nxt_i,
    output seq_t cur_o
);
    localparam addr_t STEP   = addr_t'(INSTR_BYTES);
    localparam addr_t LOWMSK = addr_t'(INSTR_BYTES - 1);
    localparam addr_t RV_AL  = RESET_VEC & ~LOWMSK;

    // State register with synchronous reset and a hold when not advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o.pc        <= RV_AL;
            cur_o.npc       <= RV_AL + STEP;
            cur_o.pend      <= '0;
            cur_o.redir     <= 1'b0;
            cur_o.pend_vld  <= 1'b0;
            cur_o.slot_kill <= 1'b0;
        end else if (adv_i) begin
            cur_o <= nxt_i;
        end
    end

    // R2
    seq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_o.redir |-> cur_o.npc == cur_o.pc + STEP);

    // R4
    pend_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_o.pend_vld |-> cur_o.redir);

    // R10
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_o.pc & LOWMSK) == '0) && ((cur_o.npc & LOWMSK) == '0));
endmodule

// File: rtl/brslot_pc_seq.sv
// Fetch address sequencer for a core with one branch delay slot.
// Assumes decode inputs describe the instruction at fetch_addr_o this cycle
// and are consumed only when stall_i is low.
module brslot_pc_seq
    import brslot_pkg::*;
#(
    parameter logic [31:0] RESET_VEC   = 32'h0000_0100,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stall_i,
    input  logic        br_valid_i,
    input  logic        br_taken_i,
    input  logic        br_annul_i,
    input  logic [31:0] br_target_i,
    output logic [31:0] fetch_addr_o,
    output logic        fetch_valid_o
);
    dec_t dec;
    seq_t cur;
    seq_t nxt;

    // Bundle the decode report.
    always_comb begin
        dec.br     = br_valid_i;
        dec.taken  = br_taken_i;
        dec.annul  = br_annul_i;
        dec.target = br_target_i;
    end

    brslot_next #(.INSTR_BYTES(INSTR_BYTES)) u_next (
        .cur_i (cur),
        .dec_i (dec),
        .nxt_o (nxt)
    );

    brslot_state #(.RESET_VEC(RESET_VEC), .INSTR_BYTES(INSTR_BYTES)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (!stall_i),
        .nxt_i (nxt),
        .cur_o (cur)
    );

    // Present the current address and whether it is a live instruction.
    always_comb begin
        fetch_addr_o  = cur.pc;
        fetch_valid_o = !cur.slot_kill;
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(fetch_addr_o) && $stable(fetch_valid_o));

    // R3
    slot_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && fetch_valid_o && br_valid_i && br_taken_i && !cur.redir)
        |=> fetch_addr_o == $past(fetch_addr_o) + 32'(INSTR_BYTES));

    // R6
    annul_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && fetch_valid_o && br_valid_i && br_annul_i && !cur.pend_vld)
        |=> !fetch_valid_o);

    // R7
    dead_slot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !fetch_valid_o) |=> fetch_valid_o);
endmodule

// File: tb/brslot_pc_seq_tb.sv
module brslot_pc_seq_tb_top;
    localparam logic [31:0] RV_RAW = 32'h0000_0102;
    localparam logic [31:0] RV     = 32'h0000_0100;

    typedef struct packed {
        logic        br;
        logic        tk;
        logic        an;
        logic [31:0] tgt;
    } tdec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic        br_valid_i = 1'b0;
    logic        br_taken_i = 1'b0;
    logic        br_annul_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic [31:0] fetch_addr_o;
    logic        fetch_valid_o;

    int          n_chk = 0;
    int          n_fail = 0;
    int          scn = 0;
    logic [31:0] seed = '0;
    logic        done = 1'b0;

    // model state for the random sweep
    logic [31:0] m_pc, m_npc, m_pend;
    logic        m_red, m_pv, m_kill;

    always #2.5 clk = ~clk;

    brslot_pc_seq #(.RESET_VEC(RV_RAW), .INSTR_BYTES(4)) dut_i (
        .clk, .rst_n, .stall_i, .br_valid_i, .br_taken_i, .br_annul_i,
        .br_target_i, .fetch_addr_o, .fetch_valid_o
    );

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic tdec_t br_at(input logic [31:0] t, input logic an);
        tdec_t d;
        d.br = 1'b1; d.tk = 1'b1; d.an = an; d.tgt = t;
        return d;
    endfunction

    // Program contents per scenario, indexed by the fetch address.
    function automatic tdec_t prog(input logic [31:0] a);
        tdec_t d = '0;
        logic [31:0] h;
        case (scn)
            1, 6: if (a == 32'h108) d = br_at(32'h200, 1'b0);
            2: begin
                if (a == 32'h108) d = br_at(32'h200, 1'b0);
                if (a == 32'h10C) d = br_at(32'h300, 1'b0);
            end
            3: if (a == 32'h108) d = br_at(32'h200, 1'b1);
            4: if (a == 32'h108) begin d = br_at(32'h200, 1'b1); d.tk = 1'b0; end
            5: if (a == 32'h108) begin d = br_at(32'h200, 1'b0); d.tk = 1'b0; end
            7: if (a == 32'h108) d = br_at(32'h203, 1'b0);
            8: begin
                if (a == 32'h108) d = br_at(32'h200, 1'b1);
                if (a == 32'h10C) d = br_at(32'h400, 1'b1);
            end
            9: begin
                if (a == 32'h108) d = br_at(32'h200, 1'b0);
                if (a == 32'h10C) d = br_at(32'h300, 1'b0);
                if (a == 32'h110) d = br_at(32'h400, 1'b1);
            end
            10: begin
                h = mix(a ^ seed);
                d.br  = (h[1:0] == 2'b00);
                d.tk  = h[2];
                d.an  = h[3] & h[4];
                d.tgt = 32'h1000 | {24'h0, h[13:8], 2'b00} | {30'h0, h[15:14]};
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    task automatic chk(input logic [31:0] ea, input logic ev, input string tag);
        n_chk++;
        if (fetch_addr_o !== ea || fetch_valid_o !== ev) begin
            n_fail++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     tag, fetch_addr_o, fetch_valid_o, ea, ev);
        end
    endtask

    task automatic drive(input tdec_t d, input logic stl);
        br_valid_i  = d.br;
        br_taken_i  = d.tk;
        br_annul_i  = d.an;
        br_target_i = d.tgt;
        stall_i     = stl;
    endtask

    // Check the presented fetch, drive decode for it, advance one cycle.
    task automatic cyc(input logic [31:0] ea, input logic ev, input string tag,
                       input logic stl = 1'b0);
        chk(ea, ev, tag);
        drive(prog(fetch_addr_o), stl);
        @(negedge clk);
    endtask

    task automatic do_reset(input int s);
        @(negedge clk);
        rst_n = 1'b0;
        scn = s;
        drive('0, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle of the random sweep against an address-pair model.
    task automatic sweep_cycle(input int k);
        tdec_t d;
        logic  stl, eb, et;
        logic [31:0] h2;
        chk(m_pc, !m_kill, "R4 sweep");
        d  = prog(m_pc);
        h2 = mix(seed + 32'(k) * 32'h9E37_79B9);
        stl = (h2[2:0] == 3'b000);
        drive(d, stl);
        if (!stl) begin
            eb = d.br && !m_kill && !m_pv;
            et = eb && d.tk;
            m_kill = eb && d.an;
            if (et && m_red) begin
                m_pc = m_pc + 4; m_pend = d.tgt & ~32'h3; m_pv = 1'b1;
            end else begin
                m_pc = m_npc;
                if (et) begin m_npc = d.tgt & ~32'h3; m_red = 1'b1; end
                else if (m_pv) begin m_npc = m_pend; m_red = 1'b1; m_pv = 1'b0; end
                else begin m_npc = m_npc + 4; m_red = 1'b0; end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // S1 single taken branch, R1 reset with unaligned vector
        do_reset(1);
        cyc(RV, 1'b1, "R1 reset vector");
        cyc(32'h104, 1'b1, "R1 sequential after reset");
        cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b1, "R3 delay slot");
        cyc(32'h200, 1'b1, "R3 target");
        cyc(32'h204, 1'b1, "R2 after target");
        // S2 taken branch in taken branch's slot
        do_reset(2);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b1, "R4 second branch");
        cyc(32'h110, 1'b1, "R4 own slot");
        cyc(32'h200, 1'b1, "R4 one at first target");
        cyc(32'h300, 1'b1, "R4 second target");
        cyc(32'h304, 1'b1, "R4 resume");
        // S3 annulled taken, stalled on the dead slot
        do_reset(3);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b0, "R9 stall on dead slot", 1'b1);
        cyc(32'h10C, 1'b0, "R6 annulled slot");
        cyc(32'h200, 1'b1, "R6 target valid");
        // S4 not-taken annulled
        do_reset(4);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b0, "R6 not-taken annul");
        cyc(32'h110, 1'b1, "R8 sequence kept");
        // S5 not-taken plain
        do_reset(5);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b1, "R8 slot valid");
        cyc(32'h110, 1'b1, "R8 sequential");
        // S6 stalls around a taken branch
        do_reset(6);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2");
        cyc(32'h108, 1'b1, "R9", 1'b1);
        cyc(32'h108, 1'b1, "R9 hold", 1'b1);
        cyc(32'h108, 1'b1, "R9 hold");
        cyc(32'h10C, 1'b1, "R9 single accept", 1'b1);
        cyc(32'h10C, 1'b1, "R9 hold slot");
        cyc(32'h200, 1'b1, "R3 after stall");
        // S7 unaligned target
        do_reset(7);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b1, "R3");
        cyc(32'h200, 1'b1, "R10 target low bits cleared");
        // S8 branch inside an annulled slot
        do_reset(8);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b0, "R6");
        cyc(32'h200, 1'b1, "R7 dead-slot branch ignored");
        cyc(32'h204, 1'b1, "R7 sequence kept");
        // S9 third taken branch in the chain
        do_reset(9);
        cyc(32'h100, 1'b1, "R1"); cyc(32'h104, 1'b1, "R2"); cyc(32'h108, 1'b1, "R2");
        cyc(32'h10C, 1'b1, "R4");
        cyc(32'h110, 1'b1, "R5 third branch");
        cyc(32'h200, 1'b1, "R5 first target, third ignored");
        cyc(32'h300, 1'b1, "R5 held target");
        cyc(32'h304, 1'b1, "R5 annul ignored");
        // random sweep with stalls
        for (int s = 0; s < 4; s++) begin
            seed = 32'hACE1_0000 + 32'(s) * 32'h0101_7F3D;
            do_reset(10);
            m_pc = RV; m_npc = RV + 4; m_pend = '0;
            m_red = 1'b0; m_pv = 1'b0; m_kill = 1'b0;
            for (int k = 0; k < 1500; k++) sweep_cycle(k);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule